// File: doc/BRIEF.md
# Two-Level Voltage/Frequency Cycle Scheduler

This block plans and then drives the execution of one task on a processor that has only a few discrete operating points, each a supply level paired with its own clock frequency. It receives the task's worst-case cycle count, a deadline in time units, and a table of level frequencies in cycles per time unit, sorted so that higher level indices are faster. It works out the ideal continuous frequency, which is cycles over deadline. It takes the two table entries on either side of that frequency. It then computes how many cycles must run on the faster entry so that the whole task ends no later than the deadline while using as few fast cycles as possible. Mixing two neighbouring levels in this way gives the lowest energy that discrete levels allow. Switching between levels is taken to cost no time.

The bracketing pair is found by a scan that tests one table entry per clock. The cycle split needs a division, which an iterative divider produces one quotient bit per clock. Once the plan is ready, a sequencer drives the level select. It applies the faster level first and moves to the slower one after the planned number of fast cycles has been executed. It gives a one-cycle done pulse after the last task cycle. A new request is accepted only while the block is idle.

Top module: `dvs_two_level_sched`

## Requirements
- R1: After reset, busy, plan_valid, run_active, done and infeasible are all low.
- R2: Table entry i occupies bits [i*FW +: FW] of freq_table and entries rise with i. The chosen upper level lvl_hi is the lowest index i with f[i]*deadline >= cycles, and lvl_lo = lvl_hi - 1.
- R3: Only one level is used (lvl_lo = lvl_hi, n_hi = cycles, n_lo = 0) in two cases: when f[lvl_hi]*deadline equals cycles exactly, and when lvl_hi is 0.
- R4: If no entry satisfies f[i]*deadline >= cycles, infeasible is raised, both level outputs are NLEV-1, n_hi = cycles and n_lo = 0. Otherwise infeasible is low.
- R5: n_hi + n_lo always equals the requested cycle count.
- R6: For a feasible request, n_hi/f[lvl_hi] + n_lo/f[lvl_lo] does not exceed the deadline.
- R7: For a feasible request with two distinct levels, n_hi is the smallest value that meets R6. Moving one cycle from the upper to the lower level would miss the deadline.
- R8: During the run, the first n_hi executed cycles show lvl_sel = lvl_hi and the remaining n_lo cycles show lvl_sel = lvl_lo. A cycle counts as executed only when run_active and exec_tick are both high at a clock edge.
- R9: done is a single-cycle pulse in the cycle after the last executed task cycle. run_active is low in that same cycle. The request cycle count must be at least 1.
- R10: A start pulse while busy is high is ignored. No further plan is produced, and the block returns to idle after the current run.
- R11: plan_valid pulses once per accepted request, with the plan outputs already valid, in the cycle just before run_active rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| cycles_in | input | CW | Worst-case task cycle count |
| deadline_in | input | TW | Deadline in time units |
| freq_table | input | NLEV*FW | Level frequencies in cycles per time unit, ascending |
| exec_tick | input | 1 | One task cycle retires at this edge |
| busy | output | 1 | A request is being planned or run |
| plan_valid | output | 1 | One-cycle pulse marking a fresh plan |
| infeasible | output | 1 | Even the fastest level misses the deadline |
| lvl_hi | output | LW | Upper level index |
| lvl_lo | output | LW | Lower level index |
| n_hi | output | CW | Cycles planned at the upper level |
| n_lo | output | CW | Cycles planned at the lower level |
| lvl_sel | output | LW | Level to apply now |
| run_active | output | 1 | Sequencer is executing the plan |
| done | output | 1 | Pulse after the last task cycle |

## Verification
If the scan stops at the wrong entry, the wrong pair shows up on lvl_hi and lvl_lo at plan_valid. That is a few clocks after start. A divider fault shows up as an n_hi that either breaks the deadline inequality or is not minimal, and it appears at the same pulse. Counter faults in the sequencer appear during the run. They show as a level switch one cycle early or late, or as a done pulse that does not follow the final executed cycle. Both are seen within the run's length. The sweep covers every table position, exact-fit and infeasible deadlines, and gapped execute ticks.

// File: rtl/dvs_sched_pkg.sv
package dvs_sched_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SCAN,
      ST_DIV,
      ST_RUN
   } sched_state_e;
endpackage

// File: rtl/dvs_level_scan.sv
module dvs_level_scan #(
   parameter int NLEV = 4,
   parameter int FW   = 8,
   parameter int CW   = 16,
   parameter int TW   = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [CW-1:0]          cyc,
   input  logic [TW-1:0]          dl,
   input  logic [NLEV*FW-1:0]     ftab,
   output logic                   done,
   output logic                   found,
   output logic                   exact,
   output logic [$clog2(NLEV)-1:0] idx
);
   localparam int LW = $clog2(NLEV);
   localparam int PW = FW + TW;

   logic [FW-1:0] f_arr [NLEV];
   for (genvar g = 0; g < NLEV; g++) begin : g_unpack
      assign f_arr[g] = ftab[g*FW +: FW];
   end

   logic          act;
   logic [LW-1:0] cur;
   logic [PW-1:0] prod, cyc_ext;

   assign prod    = PW'(f_arr[cur]) * PW'(dl);
   assign cyc_ext = PW'(cyc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act   <= 1'b0;
         cur   <= '0;
         done  <= 1'b0;
         found <= 1'b0;
         exact <= 1'b0;
         idx   <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            act <= 1'b1;
            cur <= '0;
         end else if (act) begin
            if (prod >= cyc_ext) begin
               act   <= 1'b0;
               done  <= 1'b1;
               found <= 1'b1;
               exact <= (prod == cyc_ext);
               idx   <= cur;
            end else if (cur == LW'(NLEV-1)) begin
               act   <= 1'b0;
               done  <= 1'b1;
               found <= 1'b0;
               exact <= 1'b0;
               idx   <= cur;
            end else begin
               cur <= cur + 1'b1;
            end
         end
      end
   end

   assert_scan_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> (int'(cur) < NLEV));
   assert_scan_single_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/dvs_iter_div.sv
module dvs_iter_div #(
   parameter int NW = 25,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          done,
   output logic [NW-1:0] quo
);
   localparam int KW = $clog2(NW + 1);

   logic [DW-1:0] rem;
   logic [DW:0]   sh;
   logic [KW-1:0] cnt;
   logic          run;

   assign sh = {rem, quo[NW-1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem  <= '0;
         quo  <= '0;
         cnt  <= '0;
         run  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem <= '0;
            quo <= num;
            cnt <= KW'(NW);
            run <= 1'b1;
         end else if (run) begin
            if (sh >= {1'b0, den}) begin
               rem <= DW'(sh - {1'b0, den});
               quo <= {quo[NW-2:0], 1'b1};
            end else begin
               rem <= sh[DW-1:0];
               quo <= {quo[NW-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == KW'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assert_rem_below_divisor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && den != '0) |-> (rem < den));
endmodule

// File: rtl/dvs_run_seq.sv
module dvs_run_seq #(
   parameter int CW = 16,
   parameter int LW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] n_hi,
   input  logic [CW-1:0] n_lo,
   input  logic [LW-1:0] lvl_hi,
   input  logic [LW-1:0] lvl_lo,
   input  logic          tick,
   output logic [LW-1:0] lvl_sel,
   output logic          active,
   output logic          done
);
   logic [CW-1:0] cnt_hi, cnt_lo;
   logic          last;

   assign lvl_sel = (active && cnt_hi == '0) ? lvl_lo : lvl_hi;
   assign last    = (cnt_hi == CW'(1) && cnt_lo == '0) ||
                    (cnt_hi == '0 && cnt_lo == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_hi <= '0;
         cnt_lo <= '0;
         active <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            cnt_hi <= n_hi;
            cnt_lo <= n_lo;
            if (n_hi == '0 && n_lo == '0) done   <= 1'b1;
            else                          active <= 1'b1;
         end else if (active && tick) begin
            if (cnt_hi != '0) cnt_hi <= cnt_hi - 1'b1;
            else              cnt_lo <= cnt_lo - 1'b1;
            if (last) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assert_active_has_work_R5: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt_hi != '0 || cnt_lo != '0));
   assert_hi_phase_ends_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !load && cnt_hi == '0) |=> (cnt_hi == '0));
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_ends_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !active);
endmodule

// File: rtl/dvs_two_level_sched.sv
module dvs_two_level_sched #(
   parameter int NLEV = 4,
   parameter int FW   = 8,
   parameter int CW   = 16,
   parameter int TW   = 16,
   localparam int LW  = $clog2(NLEV)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CW-1:0]      cycles_in,
   input  logic [TW-1:0]      deadline_in,
   input  logic [NLEV*FW-1:0] freq_table,
   input  logic               exec_tick,
   output logic               busy,
   output logic               plan_valid,
   output logic               infeasible,
   output logic [LW-1:0]      lvl_hi,
   output logic [LW-1:0]      lvl_lo,
   output logic [CW-1:0]      n_hi,
   output logic [CW-1:0]      n_lo,
   output logic [LW-1:0]      lvl_sel,
   output logic               run_active,
   output logic               done
);
   import dvs_sched_pkg::*;

   localparam int PW = FW + TW;
   localparam int NW = CW + FW + 1;

   if (NLEV < 2) begin : g_bad_nlev
      $error("NLEV must be at least 2");
   end
   if (CW > PW) begin : g_bad_cw
      $error("CW must not exceed FW+TW");
   end

   logic [FW-1:0] f_arr [NLEV];
   for (genvar g = 0; g < NLEV; g++) begin : g_unpack
      assign f_arr[g] = freq_table[g*FW +: FW];
   end

   sched_state_e  st;
   logic [CW-1:0] c_q;
   logic [TW-1:0] t_q;
   logic          scan_start, div_start, seq_load;
   logic          scan_done, scan_found, scan_exact;
   logic [LW-1:0] scan_idx;
   logic          div_done;
   logic [NW-1:0] div_quo, div_num;
   logic [FW-1:0] f_hi, f_lo, den;
   logic [PW-1:0] lo_time;
   logic [CW-1:0] slack;
   logic          seq_done;

   assign f_hi    = f_arr[lvl_hi];
   assign f_lo    = f_arr[lvl_lo];
   assign den     = f_hi - f_lo;
   assign lo_time = PW'(f_lo) * PW'(t_q);
   assign slack   = CW'(PW'(c_q) - lo_time);
   assign div_num = NW'(slack) * NW'(f_hi) + NW'(den) - NW'(1);

   assign busy       = (st != ST_IDLE);
   assign plan_valid = seq_load;

   dvs_level_scan #(.NLEV(NLEV), .FW(FW), .CW(CW), .TW(TW)) u_scan (
      .clk(clk), .rst_n(rst_n), .start(scan_start), .cyc(c_q), .dl(t_q),
      .ftab(freq_table), .done(scan_done), .found(scan_found),
      .exact(scan_exact), .idx(scan_idx));

   dvs_iter_div #(.NW(NW), .DW(FW)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(den),
      .done(div_done), .quo(div_quo));

   dvs_run_seq #(.CW(CW), .LW(LW)) u_seq (
      .clk(clk), .rst_n(rst_n), .load(seq_load), .n_hi(n_hi), .n_lo(n_lo),
      .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .tick(exec_tick), .lvl_sel(lvl_sel),
      .active(run_active), .done(seq_done));

   assign done = seq_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         c_q        <= '0;
         t_q        <= '0;
         scan_start <= 1'b0;
         div_start  <= 1'b0;
         seq_load   <= 1'b0;
         infeasible <= 1'b0;
         lvl_hi     <= '0;
         lvl_lo     <= '0;
         n_hi       <= '0;
         n_lo       <= '0;
      end else begin
         scan_start <= 1'b0;
         div_start  <= 1'b0;
         seq_load   <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               c_q        <= cycles_in;
               t_q        <= deadline_in;
               scan_start <= 1'b1;
               st         <= ST_SCAN;
            end
            ST_SCAN: if (scan_done) begin
               if (!scan_found) begin
                  infeasible <= 1'b1;
                  lvl_hi     <= LW'(NLEV-1);
                  lvl_lo     <= LW'(NLEV-1);
                  n_hi       <= c_q;
                  n_lo       <= '0;
                  seq_load   <= 1'b1;
                  st         <= ST_RUN;
               end else if (scan_exact || scan_idx == '0) begin
                  infeasible <= 1'b0;
                  lvl_hi     <= scan_idx;
                  lvl_lo     <= scan_idx;
                  n_hi       <= c_q;
                  n_lo       <= '0;
                  seq_load   <= 1'b1;
                  st         <= ST_RUN;
               end else begin
                  infeasible <= 1'b0;
                  lvl_hi     <= scan_idx;
                  lvl_lo     <= scan_idx - 1'b1;
                  div_start  <= 1'b1;
                  st         <= ST_DIV;
               end
            end
            ST_DIV: if (div_done) begin
               n_hi     <= div_quo[CW-1:0];
               n_lo     <= c_q - div_quo[CW-1:0];
               seq_load <= 1'b1;
               st       <= ST_RUN;
            end
            ST_RUN: if (seq_done) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_split_within_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DIV && div_done) |-> (div_quo <= NW'(c_q)));
   assert_request_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !seq_done) |=> $stable(c_q) && $stable(t_q));
   assert_infeasible_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (plan_valid && infeasible) |-> (lvl_hi == LW'(NLEV-1) && n_lo == '0));
   assert_plan_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
      plan_valid |=> !plan_valid);
endmodule

// File: tb/dvs_two_level_sched_test.sv
module dvs_two_level_sched_test;
   localparam int NLEV = 4;
   localparam int FW   = 8;
   localparam int CW   = 16;
   localparam int TW   = 16;
   localparam int LW   = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [CW-1:0]      cycles_in = '0;
   logic [TW-1:0]      deadline_in = '0;
   logic [NLEV*FW-1:0] freq_table;
   logic               exec_tick = 1'b1;
   logic               busy, plan_valid, infeasible, run_active, done;
   logic [LW-1:0]      lvl_hi, lvl_lo, lvl_sel;
   logic [CW-1:0]      n_hi, n_lo;

   int checks = 0;
   int fails  = 0;
   int fr [NLEV] = '{10, 25, 40, 60};

   always #5 clk = ~clk;

   assign freq_table = {8'(fr[3]), 8'(fr[2]), 8'(fr[1]), 8'(fr[0])};

   dvs_two_level_sched #(.NLEV(NLEV), .FW(FW), .CW(CW), .TW(TW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cycles_in(cycles_in),
      .deadline_in(deadline_in), .freq_table(freq_table), .exec_tick(exec_tick),
      .busy(busy), .plan_valid(plan_valid), .infeasible(infeasible),
      .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .n_hi(n_hi), .n_lo(n_lo),
      .lvl_sel(lvl_sel), .run_active(run_active), .done(done));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic one_run(input int c, input int t, input bit gappy, input bit inject);
      int hi_e, lo_e, nh_e, k, got, mism, last_i, done_i, i;
      bit inf_e, seen;
      k = -1;
      for (int j = 0; j < NLEV; j++)
         if (k < 0 && fr[j] * t >= c) k = j;
      if (k < 0) begin
         inf_e = 1; hi_e = NLEV-1; lo_e = NLEV-1; nh_e = c;
      end else if (k == 0 || fr[k] * t == c) begin
         inf_e = 0; hi_e = k; lo_e = k; nh_e = c;
      end else begin
         inf_e = 0; hi_e = k; lo_e = k-1;
         nh_e = ((c - t*fr[k-1]) * fr[k] + fr[k] - fr[k-1] - 1) / (fr[k] - fr[k-1]);
      end
      @(negedge clk);
      cycles_in = CW'(c); deadline_in = TW'(t); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      i = 0;
      seen = 0;
      while (!seen && i < 200) begin
         @(negedge clk); exec_tick = 1'b1; #1;
         if (plan_valid) seen = 1;
         i++;
      end
      check(seen && !run_active, "R11 plan_valid before run", plan_valid, 1);
      check(int'(lvl_hi) == hi_e, "R2 lvl_hi", lvl_hi, hi_e);
      check(int'(lvl_lo) == lo_e, "R2/R3 lvl_lo", lvl_lo, lo_e);
      check(infeasible == inf_e, "R4 infeasible", infeasible, inf_e);
      check(int'(n_hi) == nh_e, "R3/R4 n_hi", n_hi, nh_e);
      check(int'(n_hi) + int'(n_lo) == c, "R5 split sum", n_hi + n_lo, c);
      if (!inf_e) begin
         check(longint'(n_hi)*fr[lo_e] + longint'(n_lo)*fr[hi_e] <= longint'(t)*fr[hi_e]*fr[lo_e],
               "R6 deadline met", longint'(n_hi)*fr[lo_e] + longint'(n_lo)*fr[hi_e],
               longint'(t)*fr[hi_e]*fr[lo_e]);
         if (hi_e != lo_e && n_hi > 0)
            check(longint'(n_hi-1)*fr[lo_e] + longint'(n_lo+1)*fr[hi_e] > longint'(t)*fr[hi_e]*fr[lo_e],
                  "R7 n_hi minimal", n_hi, nh_e);
      end
      got = 0; mism = 0; last_i = -1; done_i = -1; seen = 0; i = 0;
      while (!seen && i < 3000) begin
         @(negedge clk);
         start = 1'b0;
         if (inject && got == 2) begin
            cycles_in = 16'd5; deadline_in = 16'd1; start = 1'b1;
         end
         exec_tick = gappy ? ((i % 3) != 1) : 1'b1;
         #1;
         if (done) begin
            seen = 1; done_i = i;
            check(!run_active, "R9 run_active low at done", run_active, 0);
         end else if (run_active && exec_tick) begin
            if (int'(lvl_sel) != ((got < nh_e) ? hi_e : lo_e)) mism++;
            got++;
            if (got == c) last_i = i;
         end
         i++;
      end
      start = 1'b0;
      check(mism == 0, "R8 level order", mism, 0);
      check(got == c, "R8 executed cycles", got, c);
      check(done_i == last_i + 1 && last_i >= 0, "R9 done timing", done_i, last_i + 1);
      @(negedge clk); #1;
      check(!done, "R9 done single pulse", done, 0);
      if (inject) begin
         seen = 0;
         for (int w = 0; w < 60; w++) begin
            @(negedge clk); #1;
            if (plan_valid || busy) seen = 1;
         end
         check(!seen, "R10 start while busy ignored", seen, 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int cs [6] = '{1, 9, 37, 100, 150, 240};
      repeat (3) @(negedge clk);
      #1;
      check(!busy && !plan_valid && !run_active && !done && !infeasible,
            "R1 reset state", {busy, plan_valid, run_active, done, infeasible}, 0);
      rst_n = 1'b1;
      one_run(100, 5, 1'b0, 1'b1);
      one_run(50, 2, 1'b0, 1'b0);
      for (int a = 0; a < 6; a++)
         for (int t = 1; t <= 26; t++)
            one_run(cs[a], t, (t % 2) == 1, 1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule